// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a counter core for general-purpose timing. A prescaler divides the block clock by a programmable power of two before it reaches the counter. The counter can run upward, downward, or in a triangle between zero and a TOP limit. It can also follow a pair of quadrature phase inputs and count their edges at double or quadruple resolution. Count steps in the timed modes can be one or two.

A single trigger input can control the counter. Its rising and falling edges each carry a configurable action: nothing, start, stop, or reload-and-start. Two command strobes start and stop the counter directly. In one-shot operation the counter halts by itself after one full count cycle. A new TOP value is written into a holding buffer and only takes effect at the next wrap or reload, so the period can be changed while the counter is running without a glitch.

Control lives in a two-state machine. `ST_IDLE` moves to `ST_RUN` on transition GO, which is a start command or a start or reload trigger action with no stop present in the same cycle. `ST_RUN` returns to `ST_IDLE` on transition HALT, which is a stop command or a stop trigger action. `ST_RUN` also returns to `ST_IDLE` on transition ONESHOT_DONE, which is the end of a count cycle while one-shot is set and no GO is present. In every other case the state holds.

Top module: `mmtimer_core`

## Requirements
- R1: After reset the count is 0, both strobes are low, the direction is 0 (up), the counter is idle, and TOP holds all ones.
- R2: With prescale code n (values above 10 act as 10), a timed mode advances once every 2^n clock cycles. The first advance comes 2^n cycles after the start or reload edge.
- R3: Mode 0 (up) counts from 0 to TOP, then wraps to 0. `ovf_o` is high for one cycle together with the 0.
- R4: Mode 1 (down) counts toward 0, then wraps to TOP. `unf_o` is high for one cycle together with the TOP value. `dir_o` is 1.
- R5: In mode 2 (up/down), counting up and reaching TOP gives one `ovf_o` cycle and turns the direction to down (`dir_o`=1). Counting down and reaching 0 gives one `unf_o` cycle and turns it back to up.
- R6: With `cfg_step2` set, each timed advance moves the count by 2. An up step that would pass TOP wraps to 0.
- R7: Trigger action codes are 0 none, 1 start, 2 stop, 3 reload-and-start, chosen separately for rising and falling edges. A stopped counter keeps its value. The edge that stops the counter still performs that cycle's advance.
- R8: A reload sets the count to 0 in modes 0, 2 and 3, and to TOP in mode 1.
- R9: A stop (command or trigger) in the same cycle as any start request wins, and the counter stays idle.
- R10: In one-shot mode the counter halts after its first wrap in modes 0, 1 and 3, and after the first return to 0 in mode 2.
- R11: A TOP buffer write is applied at the next wrap or reload. A write in the same cycle as a wrap is not taken by that wrap; it waits for the following one.
- R12: In mode 3 with X2 resolution, only edges of phase A are counted. The count goes up when A's new level differs from B, and down otherwise. The prescaler has no effect.
- R13: In mode 3 with X4 resolution, edges of phase B also count: up when B's new level equals A, down otherwise. A cycle in which both phases change is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 up, 1 down, 2 up/down, 3 quadrature |
| cfg_presc | input | PRESC_W | Prescale exponent n |
| cfg_step2 | input | 1 | Step by 2 in timed modes |
| cfg_oneshot | input | 1 | Halt after one count cycle |
| cfg_x4 | input | 1 | Quadrature X4 resolution when set, X2 when clear |
| cfg_rise_act | input | 2 | Action on trigger rising edge |
| cfg_fall_act | input | 2 | Action on trigger falling edge |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| trig_i | input | 1 | Trigger input, synchronous |
| quad_a_i | input | 1 | Quadrature phase A, synchronous |
| quad_b_i | input | 1 | Quadrature phase B, synchronous |
| top_wr_i | input | 1 | Write strobe for the TOP buffer |
| top_data_i | input | CW | TOP buffer write data |
| count_o | output | CW | Counter value |
| ovf_o | output | 1 | Overflow strobe |
| unf_o | output | 1 | Underflow strobe |
| dir_o | output | 1 | 0 up, 1 down |
| running_o | output | 1 | High in ST_RUN |

## Verification
The case of most interest is a TOP buffer write landing in the same cycle as a wrap. The bench lines the write strobe up exactly with the edge where an up count passes TOP. It expects the old period to repeat once before the new TOP shows up, and it checks the count against that expectation cycle by cycle. A second run places the write away from the wrap, where the new TOP must take effect at the very next wrap. The bench also drives a stop command together with a start trigger, and moves both quadrature phases in one cycle, to check the priority rules.

// File: rtl/mmtimer_pkg.sv
package mmtimer_pkg;
    localparam int PRESC_MAX_EXP = 10;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_QUAD   = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_START  = 2'd1,
        ACT_STOP   = 2'd2,
        ACT_RELOAD = 2'd3
    } tmr_act_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/mmtimer_presc.sv
module mmtimer_presc
    import mmtimer_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    localparam int DW = PRESC_MAX_EXP;

    logic [DW-1:0] pcnt_q;
    logic [DW-1:0] mask;
    logic [PW-1:0] n_eff;

    always_comb begin
        n_eff = (presc > PW'(PRESC_MAX_EXP)) ? PW'(PRESC_MAX_EXP) : presc;
        mask  = ~({DW{1'b1}} << n_eff);
        tick  = run && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (!run || clr)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    AST_PRESC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && n_eff != '0 && $stable(presc) && $past(run)) |-> !$past(tick)) // R2
        else $error("prescaled tick on consecutive cycles");
endmodule

// File: rtl/mmtimer_inputs.sv
module mmtimer_inputs
    import mmtimer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [1:0] rise_act,
    input  logic [1:0] fall_act,
    input  logic       qa,
    input  logic       qb,
    input  logic       x4,
    output tmr_act_e   act,
    output logic       q_step,
    output logic       q_up
);
    logic trig_q, qa_q, qb_q;
    logic qa_edge, qb_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            qa_q   <= 1'b0;
            qb_q   <= 1'b0;
        end else begin
            trig_q <= trig;
            qa_q   <= qa;
            qb_q   <= qb;
        end
    end

    always_comb begin
        act = ACT_NONE;
        if (trig && !trig_q)
            act = tmr_act_e'(rise_act);
        else if (!trig && trig_q)
            act = tmr_act_e'(fall_act);

        qa_edge = qa ^ qa_q;
        qb_edge = qb ^ qb_q;
        q_step  = 1'b0;
        q_up    = 1'b0;
        if (qa_edge && !qb_edge) begin
            q_step = 1'b1;
            q_up   = (qa != qb);
        end else if (qb_edge && !qa_edge && x4) begin
            q_step = 1'b1;
            q_up   = (qb == qa);
        end
    end
endmodule

// File: rtl/mmtimer_ctrl.sv
module mmtimer_ctrl
    import mmtimer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_act_e act,
    input  logic     cmd_start,
    input  logic     cmd_stop,
    input  logic     oneshot,
    input  logic     cyc_end,
    output logic     run,
    output logic     load
);
    tmr_state_e state_q, state_d;
    logic halt, go;

    always_comb begin
        halt    = cmd_stop || (act == ACT_STOP);
        go      = cmd_start || (act == ACT_START) || (act == ACT_RELOAD);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go && !halt) state_d = ST_RUN;
            ST_RUN: begin
                if (halt)                           state_d = ST_IDLE;
                else if (!go && oneshot && cyc_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run  = (state_q == ST_RUN);
        load = (act == ACT_RELOAD) && !cmd_stop;
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (state_q == ST_IDLE)) // R9
        else $error("stop command did not leave counter idle");
endmodule

// File: rtl/mmtimer_count.sv
module mmtimer_count
    import mmtimer_pkg::*;
#(
    parameter int            CW      = 16,
    parameter logic [CW-1:0] TOP_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          load,
    input  tmr_mode_e     mode,
    input  logic          step2,
    input  logic          q_step,
    input  logic          q_up,
    input  logic          buf_wr,
    input  logic [CW-1:0] buf_data,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_q,
    output logic          unf_q,
    output logic          dir_q,
    output logic          cyc_end
);
    logic [CW-1:0] top_q, buf_q, eff_top, n_cnt, dif;
    logic [CW:0]   stp, sum;
    logic          bufv_q, adv, go_up, n_ovf, n_unf, n_dir, upd;

    always_comb begin
        eff_top = bufv_q ? buf_q : top_q;
        stp     = (step2 && mode != MODE_QUAD) ? (CW+1)'(2) : (CW+1)'(1);
        sum     = {1'b0, cnt_q} + stp;
        dif     = cnt_q - stp[CW-1:0];
        adv     = run && !load && ((mode == MODE_QUAD) ? q_step : tick);
        go_up   = (mode == MODE_UP) || (mode == MODE_QUAD && q_up);
        n_cnt   = cnt_q;
        n_ovf   = 1'b0;
        n_unf   = 1'b0;
        n_dir   = dir_q;
        if (mode == MODE_UPDOWN) begin
            if (!dir_q) begin
                if (sum >= {1'b0, top_q}) begin
                    n_cnt = top_q; n_ovf = 1'b1; n_dir = 1'b1;
                end else begin
                    n_cnt = sum[CW-1:0];
                end
            end else begin
                if ({1'b0, cnt_q} <= stp) begin
                    n_cnt = '0; n_unf = 1'b1; n_dir = 1'b0;
                end else begin
                    n_cnt = dif;
                end
            end
        end else if (go_up) begin
            n_dir = 1'b0;
            if (sum > {1'b0, top_q}) begin
                n_cnt = '0; n_ovf = 1'b1;
            end else begin
                n_cnt = sum[CW-1:0];
            end
        end else begin
            n_dir = 1'b1;
            if ({1'b0, cnt_q} < stp) begin
                n_cnt = eff_top; n_unf = 1'b1;
            end else begin
                n_cnt = dif;
            end
        end
        cyc_end = adv && ((mode == MODE_UPDOWN) ? n_unf : (n_ovf || n_unf));
        upd     = load || (adv && (n_ovf || n_unf));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            top_q  <= TOP_RST;
            buf_q  <= '0;
            bufv_q <= 1'b0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            if (load) begin
                cnt_q <= (mode == MODE_DOWN) ? eff_top : '0;
                dir_q <= (mode == MODE_DOWN);
                top_q <= eff_top;
            end else if (adv) begin
                cnt_q <= n_cnt;
                ovf_q <= n_ovf;
                unf_q <= n_unf;
                dir_q <= n_dir;
                if (n_ovf || n_unf) top_q <= eff_top;
            end
            if (buf_wr) begin
                buf_q  <= buf_data;
                bufv_q <= 1'b1;
            end else if (upd) begin
                bufv_q <= 1'b0;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q)) // R5
        else $error("overflow and underflow together");
    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && $past(mode) == MODE_UP) |-> (cnt_q == '0)) // R3
        else $error("up wrap did not land on zero");
    AST_DOWN_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && $past(mode) == MODE_DOWN) |-> (cnt_q == top_q)) // R4
        else $error("down wrap did not land on TOP");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q)) // R7
        else $error("count moved while idle");
    AST_QUAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_QUAD && !q_step && !load) |=> $stable(cnt_q)) // R13
        else $error("quadrature count moved without a phase edge");
endmodule

// File: rtl/mmtimer_core.sv
module mmtimer_core
    import mmtimer_pkg::*;
#(
    parameter int            CW      = 16,
    parameter int            PRESC_W = 4,
    parameter logic [CW-1:0] TOP_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic               cfg_step2,
    input  logic               cfg_oneshot,
    input  logic               cfg_x4,
    input  logic [1:0]         cfg_rise_act,
    input  logic [1:0]         cfg_fall_act,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               trig_i,
    input  logic               quad_a_i,
    input  logic               quad_b_i,
    input  logic               top_wr_i,
    input  logic [CW-1:0]      top_data_i,
    output logic [CW-1:0]      count_o,
    output logic               ovf_o,
    output logic               unf_o,
    output logic               dir_o,
    output logic               running_o
);
    tmr_mode_e mode;
    tmr_act_e  act;
    logic      q_step, q_up, run, load, tick, cyc_end;

    assign mode      = tmr_mode_e'(cfg_mode);
    assign running_o = run;

    mmtimer_inputs u_inputs (
        .clk(clk), .rst_n(rst_n), .trig(trig_i),
        .rise_act(cfg_rise_act), .fall_act(cfg_fall_act),
        .qa(quad_a_i), .qb(quad_b_i), .x4(cfg_x4),
        .act(act), .q_step(q_step), .q_up(q_up)
    );

    mmtimer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .act(act),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .oneshot(cfg_oneshot), .cyc_end(cyc_end),
        .run(run), .load(load)
    );

    mmtimer_presc #(.PW(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(load),
        .presc(cfg_presc), .tick(tick)
    );

    mmtimer_count #(.CW(CW), .TOP_RST(TOP_RST)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(load),
        .mode(mode), .step2(cfg_step2), .q_step(q_step), .q_up(q_up),
        .buf_wr(top_wr_i), .buf_data(top_data_i),
        .cnt_q(count_o), .ovf_q(ovf_o), .unf_q(unf_o), .dir_q(dir_o),
        .cyc_end(cyc_end)
    );

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && $past(cfg_oneshot) && $past(cfg_mode) == 2'd0 &&
         !$past(cmd_start) && $past(act) == ACT_NONE) |-> !running_o) // R10
        else $error("one-shot counter kept running after wrap");
endmodule

// File: tb/mmtimer_core_tb_top.sv
`timescale 1ns/1ps
module mmtimer_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic [3:0]  cfg_presc;
    logic        cfg_step2, cfg_oneshot, cfg_x4;
    logic [1:0]  cfg_rise_act, cfg_fall_act;
    logic        cmd_start, cmd_stop, trig_i, quad_a_i, quad_b_i, top_wr_i;
    logic [15:0] top_data_i;
    logic [15:0] count_o;
    logic        ovf_o, unf_o, dir_o, running_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mmtimer_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_presc(cfg_presc),
        .cfg_step2(cfg_step2), .cfg_oneshot(cfg_oneshot), .cfg_x4(cfg_x4),
        .cfg_rise_act(cfg_rise_act), .cfg_fall_act(cfg_fall_act),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .trig_i(trig_i),
        .quad_a_i(quad_a_i), .quad_b_i(quad_b_i), .top_wr_i(top_wr_i),
        .top_data_i(top_data_i), .count_o(count_o), .ovf_o(ovf_o),
        .unf_o(unf_o), .dir_o(dir_o), .running_o(running_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_top(int v);
        top_wr_i = 1'b1; top_data_i = 16'(v);
        step();
        top_wr_i = 1'b0;
    endtask

    // reload-and-start on a rising trigger edge; returns with zero advances done
    task automatic restart();
        cfg_rise_act = 2'd3; cfg_fall_act = 2'd0;
        trig_i = 1'b1;
        step();
        trig_i = 1'b0;
    endtask

    task automatic qmove(logic a, logic b);
        quad_a_i = a; quad_b_i = b;
        step(2);
    endtask

    task automatic q_fwd();
        qmove(1, 0); qmove(1, 1); qmove(0, 1); qmove(0, 0);
    endtask

    task automatic q_bwd();
        qmove(0, 1); qmove(1, 1); qmove(1, 0); qmove(0, 0);
    endtask

    function automatic int exp_ud(int w, int top);
        int v = w % (2 * top);
        return (v <= top) ? v : 2 * top - v;
    endfunction

    function automatic int exp_buf_late(int w);
        return (w <= 8) ? (w % 4) : ((w - 8) % 2);
    endfunction

    function automatic int exp_buf_early(int w);
        return (w < 4) ? w : ((w - 4) % 2);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] c0, c1;
        void'($urandom(32'd7321));
        rst_n = 1'b0; cfg_mode = 2'd0; cfg_presc = '0; cfg_step2 = 1'b0;
        cfg_oneshot = 1'b0; cfg_x4 = 1'b0; cfg_rise_act = '0; cfg_fall_act = '0;
        cmd_start = 1'b0; cmd_stop = 1'b0; trig_i = 1'b0; quad_a_i = 1'b0;
        quad_b_i = 1'b0; top_wr_i = 1'b0; top_data_i = '0;
        step(3);
        rst_n = 1'b1;
        step();
        check("R1 count", count_o, 0);
        check("R1 ovf", ovf_o, 0);
        check("R1 unf", unf_o, 0);
        check("R1 dir", dir_o, 0);
        check("R1 running", running_o, 0);

        // R2 prescaler: random exponents and windows, then the clamp
        set_top(16'hFFFF);
        for (int i = 0; i < 6; i++) begin
            int unsigned n = $urandom % 6;
            int unsigned w = $urandom % 300;
            cfg_presc = 4'(n);
            restart();
            step(int'(w));
            check("R2 prescaled count", count_o, w >> n);
        end
        cfg_presc = 4'd15;
        restart();
        step(2100);
        check("R2 clamp at 1024", count_o, 2);
        cfg_presc = 4'd0;

        // R3 up mode
        set_top(5);
        restart();
        for (int w = 0; w < 14; w++) begin
            check("R3 up count", count_o, w % 6);
            check("R3 ovf strobe", ovf_o, (w > 0 && w % 6 == 0));
            step();
        end

        // R4 down mode, reload to TOP (R8)
        cfg_mode = 2'd1;
        set_top(4);
        restart();
        check("R8 down reload to TOP", count_o, 4);
        for (int w = 0; w < 12; w++) begin
            check("R4 down count", count_o, 4 - (w % 5));
            check("R4 unf strobe", unf_o, (w > 0 && w % 5 == 0));
            check("R4 dir", dir_o, 1);
            step();
        end

        // R5 up/down
        cfg_mode = 2'd2;
        set_top(3);
        restart();
        for (int w = 0; w < 14; w++) begin
            check("R5 updown count", count_o, exp_ud(w, 3));
            check("R5 ovf at TOP", ovf_o, (w % 6 == 3));
            check("R5 unf at zero", unf_o, (w > 0 && w % 6 == 0));
            check("R5 dir", dir_o, (w % 6 >= 3));
            step();
        end

        // R6 step by two
        cfg_mode = 2'd0; cfg_step2 = 1'b1;
        set_top(7);
        restart();
        for (int w = 0; w < 10; w++) begin
            check("R6 step2 count", count_o, 2 * (w % 4));
            check("R6 step2 ovf", ovf_o, (w > 0 && w % 4 == 0));
            step();
        end
        cfg_step2 = 1'b0;

        // R7 trigger actions
        set_top(16'hFFFF);
        restart();
        step(4);
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0; step();
        c0 = count_o;
        check("R7 stopped", running_o, 0);
        cfg_rise_act = 2'd1; cfg_fall_act = 2'd2;
        trig_i = 1'b1; step(5); trig_i = 1'b0; step(3);
        check("R7 start then stop", count_o, 32'(c0) + 5);
        check("R7 stop holds idle", running_o, 0);
        cfg_rise_act = 2'd0;
        trig_i = 1'b1; step(3); trig_i = 1'b0; step(3);
        check("R7 none action ignored", count_o, 32'(c0) + 5);
        check("R7 none keeps idle", running_o, 0);
        cfg_rise_act = 2'd1; cfg_fall_act = 2'd3;
        trig_i = 1'b1; step(4); trig_i = 1'b0; step();
        check("R8 falling reload to zero", count_o, 0);
        check("R8 reload runs", running_o, 1);

        // R9 stop wins
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0; step();
        c1 = count_o;
        cmd_start = 1'b1; cmd_stop = 1'b1; step();
        cmd_start = 1'b0; cmd_stop = 1'b0; step(3);
        check("R9 start+stop count", count_o, 32'(c1));
        check("R9 start+stop idle", running_o, 0);
        trig_i = 1'b1; cmd_stop = 1'b1; step();
        cmd_stop = 1'b0; step(3);
        check("R9 trigger start vs stop", running_o, 0);
        check("R9 trigger start vs stop count", count_o, 32'(c1));
        trig_i = 1'b0; cfg_fall_act = 2'd0; step();

        // R10 one-shot
        cfg_oneshot = 1'b1;
        set_top(3);
        restart();
        step(10);
        check("R10 oneshot up count", count_o, 0);
        check("R10 oneshot up idle", running_o, 0);
        cfg_mode = 2'd1;
        restart();
        step(10);
        check("R10 oneshot down count", count_o, 3);
        check("R10 oneshot down idle", running_o, 0);
        cfg_oneshot = 1'b0; cfg_mode = 2'd0;

        // R11 TOP buffer: write coinciding with wrap, then early write
        set_top(3);
        restart();
        for (int w = 0; w < 13; w++) begin
            check("R11 write at wrap", count_o, exp_buf_late(w));
            top_wr_i = (w == 3); top_data_i = 16'd1;
            step();
        end
        top_wr_i = 1'b0;
        set_top(3);
        restart();
        for (int w = 0; w < 10; w++) begin
            check("R11 write before wrap", count_o, exp_buf_early(w));
            top_wr_i = (w == 1); top_data_i = 16'd1;
            step();
        end
        top_wr_i = 1'b0;

        // R12 quadrature X2, prescaler set high to show it is ignored
        cfg_mode = 2'd3; cfg_x4 = 1'b0; cfg_presc = 4'd5;
        set_top(9);
        restart();
        q_fwd(); q_fwd();
        check("R12 x2 forward", count_o, 4);
        check("R12 x2 dir up", dir_o, 0);
        q_bwd(); q_bwd();
        check("R12 x2 backward", count_o, 0);
        q_bwd();
        check("R12 x2 wrap below zero", count_o, 8);
        check("R12 x2 dir down", dir_o, 1);

        // R13 quadrature X4
        cfg_x4 = 1'b1;
        restart();
        q_fwd();
        check("R13 x4 forward", count_o, 4);
        qmove(1, 1);
        check("R13 both phases ignored", count_o, 4);
        qmove(0, 0);
        check("R13 both phases ignored back", count_o, 4);
        q_bwd();
        check("R13 x4 backward", count_o, 0);
        qmove(0, 1);
        check("R13 B edge down wraps", count_o, 9);
        check("R13 dir down", dir_o, 1);

        done = 1'b1;
        finish_run();
    end
endmodule